// File: doc/BRIEF.md
# Segmented Piecewise-Linear Gamma Curve

This block applies one programmable transfer curve to the red, green and blue channels of a 12-bit pixel stream. The curve is piecewise linear over 64 segments. The segments are narrow near black, where the eye is most sensitive, and wide toward white. Each segment spans a power-of-two number of input codes, so the block locates the segment for an input with a few comparisons on its upper bits and shifts. It does not divide.

Software loads 65 breakpoint values, one per segment start plus one for the end of the curve, through a simple write port. The writes go into a shadow bank. A frame-start strobe copies the whole shadow bank into the working bank, so a curve never changes in the middle of a frame. For each input code the block reads the two breakpoints that bound its segment. It interpolates between them linearly and clamps the result to the 12-bit range.

A per-pixel enable selects between the curve and a plain pass-through. Every pixel has the same two-cycle latency, and a valid flag travels with it.

Top module: `gamma_pwl_curve`

## Requirements
- R1: After reset, out_valid, out_r, out_g and out_b are 0. Both breakpoint banks reset to the identity curve: breakpoint k holds the start input code of segment k, and breakpoint 64 holds 4096. With the curve enabled, the output therefore equals the input until new breakpoints are committed.
- R2: A pixel accepted with in_valid=1 at a clock edge appears on out_r/out_g/out_b, with out_valid=1, exactly two rising edges later. out_valid is 0 in any cycle that has no matching accepted pixel.
- R3: When curve_en is 0 in the cycle a pixel is accepted, that pixel leaves the block unchanged, whatever the breakpoints hold.
- R4: The segment layout is fixed. Segments 0–7 are 4 codes wide and start at 0. Segments 8–11 are 8 wide and start at 32. Segments 12–15 are 16 wide and start at 64. Segments 16–19 are 32 wide and start at 128. Segments 20–23 are 64 wide and start at 256. Segments 24–39 are 32 wide and start at 512. Segments 40–63 are 128 wide and start at 1024.
- R5: With the curve enabled, an input x in segment k, which starts at s and is w codes wide, gives B[k] + floor((B[k+1] − B[k]) · (x − s) / w). The floor rounds toward minus infinity, so descending segments are handled.
- R6: An interpolated value above 4095 is output as 4095.
- R7: A write with wr_en=1 stores wr_data (13 bits) in shadow breakpoint wr_addr for addresses 0–64. A write to an address from 65 to 127 changes no breakpoint.
- R8: Shadow writes have no effect on the output until a frame_start pulse. At that pulse all 65 shadow values become the working curve at once. A write in the same cycle as frame_start lands in the shadow bank only and takes effect at the next pulse.
- R9: The three channels share one working bank and are evaluated independently in the same cycle.
- R10: Inputs 3968–4095 use segment 63, which interpolates toward breakpoint 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Breakpoint write strobe into the shadow bank |
| wr_addr | input | 7 | Breakpoint index; 0–64 valid |
| wr_data | input | 13 | Breakpoint value |
| frame_start | input | 1 | Copies the shadow bank into the working bank |
| curve_en | input | 1 | 1 applies the curve, 0 passes the pixel through |
| in_valid | input | 1 | Input pixel valid |
| in_r | input | 12 | Red input code |
| in_g | input | 12 | Green input code |
| in_b | input | 12 | Blue input code |
| out_valid | output | 1 | Output pixel valid |
| out_r | output | 12 | Red output code |
| out_g | output | 12 | Green output code |
| out_b | output | 12 | Blue output code |

## Verification
A segment decoder with a wrong boundary or shift reads the wrong breakpoint pair. The effect shows on the very next pixel whose code falls in the affected sector, so the stimulus sweeps codes in every sector and on each sector edge. A bank that aliases out-of-range addresses, or one that updates before the strobe, shows a changed curve at the first pixel after the stray write or after the commit. Descending segments and a steep final segment reveal wrong rounding or a missing clamp within two cycles of the pixel.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int DATA_W = 12;
  localparam int BP_W   = 13;
  localparam int NBP    = 65;
  localparam int SEG_W  = 6;
  localparam int ADDR_W = 7;
  localparam int OFF_W  = 7;
  localparam int SH_W   = 3;
  localparam int NCH    = 3;

  // start code of segment k; k == 64 is the curve end
  function automatic int seg_start(input int k);
    if (k < 8)       return k * 4;
    else if (k < 12) return 32 + (k - 8) * 8;
    else if (k < 16) return 64 + (k - 12) * 16;
    else if (k < 20) return 128 + (k - 16) * 32;
    else if (k < 24) return 256 + (k - 20) * 64;
    else if (k < 40) return 512 + (k - 24) * 32;
    else if (k < 64) return 1024 + (k - 40) * 128;
    else             return 4096;
  endfunction
endpackage

// File: rtl/gamma_seg_decode.sv
module gamma_seg_decode
  import gamma_pkg::*;
#(
  parameter int X_W = DATA_W,
  parameter int S_W = SEG_W,
  parameter int O_W = OFF_W,
  parameter int H_W = SH_W
) (
  input  logic [X_W-1:0] x,
  output logic [S_W-1:0] seg,
  output logic [O_W-1:0] off,
  output logic [H_W-1:0] sh
);
  logic [X_W-1:0] mask;

  // sector chosen from the leading bits; each sector start is a multiple
  // of its segment width, so the offset is a plain mask of the low bits
  always_comb begin
    if (x[11:10] != 2'b00) begin
      seg = S_W'(40 + ((x - 12'd1024) >> 7)); sh = H_W'(7);
    end else if (x[9]) begin
      seg = S_W'(24 + ((x - 12'd512) >> 5));  sh = H_W'(5);
    end else if (x[8]) begin
      seg = S_W'(20 + ((x - 12'd256) >> 6));  sh = H_W'(6);
    end else if (x[7]) begin
      seg = S_W'(16 + ((x - 12'd128) >> 5));  sh = H_W'(5);
    end else if (x[6]) begin
      seg = S_W'(12 + ((x - 12'd64) >> 4));   sh = H_W'(4);
    end else if (x[5]) begin
      seg = S_W'(8 + ((x - 12'd32) >> 3));    sh = H_W'(3);
    end else begin
      seg = S_W'(x >> 2);                     sh = H_W'(2);
    end
    mask = (X_W'(1) << sh) - X_W'(1);
    off  = O_W'(x & mask);
  end
endmodule

// File: rtl/gamma_bp_bank.sv
module gamma_bp_bank
  import gamma_pkg::*;
#(
  parameter int CH  = NCH,
  parameter int BW  = BP_W,
  parameter int NB  = NBP,
  parameter int AW  = ADDR_W,
  parameter int SW  = SEG_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [AW-1:0]          wr_addr,
  input  logic [BW-1:0]          wr_data,
  input  logic                   commit,
  input  logic [CH-1:0][SW-1:0]  rd_idx,
  output logic [CH-1:0][BW-1:0]  rd_lo,
  output logic [CH-1:0][BW-1:0]  rd_hi
);
  logic [NB-1:0][BW-1:0] shd;
  logic [NB-1:0][BW-1:0] act;
  logic                  wr_ok;

  assign wr_ok = wr_en && (wr_addr < AW'(NB));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NB; k++) begin
        shd[k] <= BW'(seg_start(k));
        act[k] <= BW'(seg_start(k));
      end
    end else begin
      if (wr_ok) shd[wr_addr] <= wr_data;
      if (commit) act <= shd;
    end
  end

  for (genvar c = 0; c < CH; c++) begin : g_rd
    logic [AW-1:0] lo_a, hi_a;
    assign lo_a     = AW'(rd_idx[c]);
    assign hi_a     = AW'(rd_idx[c]) + AW'(1);
    assign rd_lo[c] = act[lo_a];
    assign rd_hi[c] = act[hi_a];
  end

  // R8: working curve only moves at a commit
  assert_hold_until_commit_R8: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(act));
  // R7: out-of-range writes leave the shadow bank untouched
  assert_ignore_bad_addr_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr >= AW'(NB)) |=> $stable(shd));
endmodule

// File: rtl/gamma_lane.sv
module gamma_lane
  import gamma_pkg::*;
#(
  parameter int X_W = DATA_W,
  parameter int BW  = BP_W,
  parameter int SW  = SEG_W,
  parameter int OW  = OFF_W,
  parameter int HW  = SH_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          curve_en,
  input  logic [X_W-1:0] x,
  output logic [SW-1:0] seg_idx,
  input  logic [BW-1:0] bp_lo,
  input  logic [BW-1:0] bp_hi,
  output logic          out_valid,
  output logic [X_W-1:0] out_x
);
  localparam int PW = BW + OW + 3;
  localparam int MAXV = (1 << X_W) - 1;
  localparam logic signed [PW-1:0] SAT_HI = PW'(MAXV);

  logic [OW-1:0] off;
  logic [HW-1:0] sh;

  gamma_seg_decode #(.X_W(X_W), .S_W(SW), .O_W(OW), .H_W(HW)) u_dec (
    .x(x), .seg(seg_idx), .off(off), .sh(sh)
  );

  // stage 1: capture pixel, segment position and bounding breakpoints
  logic          s1_v, s1_en;
  logic [X_W-1:0] s1_x;
  logic [OW-1:0] s1_off;
  logic [HW-1:0] s1_sh;
  logic [BW-1:0] s1_lo, s1_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v <= 1'b0; s1_en <= 1'b0; s1_x <= '0;
      s1_off <= '0; s1_sh <= '0; s1_lo <= '0; s1_hi <= '0;
    end else begin
      s1_v   <= in_valid;
      s1_en  <= curve_en;
      s1_x   <= x;
      s1_off <= off;
      s1_sh  <= sh;
      s1_lo  <= bp_lo;
      s1_hi  <= bp_hi;
    end
  end

  // stage 2: interpolate, floor by arithmetic shift, clamp
  logic signed [PW-1:0] diff, prod, step, sum;
  logic [X_W-1:0]       curve_val;

  always_comb begin
    diff = PW'($signed({1'b0, s1_hi})) - PW'($signed({1'b0, s1_lo}));
    prod = diff * PW'($signed({1'b0, s1_off}));
    step = prod >>> s1_sh;
    sum  = PW'($signed({1'b0, s1_lo})) + step;
    if (sum < 0)            curve_val = '0;
    else if (sum > SAT_HI)  curve_val = X_W'(MAXV);
    else                    curve_val = sum[X_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_x     <= '0;
    end else begin
      out_valid <= s1_v;
      out_x     <= s1_en ? curve_val : s1_x;
    end
  end

  // R5: segment start reproduces the lower breakpoint
  assert_seg_start_exact_R5: assert property (@(posedge clk) disable iff (rst)
    (s1_v && s1_en && s1_off == '0 && s1_lo <= BW'(MAXV))
      |=> (out_x == $past(s1_lo[X_W-1:0])));
  // R5: result stays between the two breakpoints of a rising segment
  assert_between_bounds_R5: assert property (@(posedge clk) disable iff (rst)
    (s1_v && s1_en && s1_lo <= s1_hi && s1_hi <= BW'(MAXV))
      |=> (BW'(out_x) >= $past(s1_lo) && BW'(out_x) <= $past(s1_hi)));
endmodule

// File: rtl/gamma_pwl_curve.sv
module gamma_pwl_curve
  import gamma_pkg::*;
#(
  parameter int X_W = DATA_W,
  parameter int BW  = BP_W,
  parameter int AW  = ADDR_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [BW-1:0]  wr_data,
  input  logic           frame_start,
  input  logic           curve_en,
  input  logic           in_valid,
  input  logic [X_W-1:0] in_r,
  input  logic [X_W-1:0] in_g,
  input  logic [X_W-1:0] in_b,
  output logic           out_valid,
  output logic [X_W-1:0] out_r,
  output logic [X_W-1:0] out_g,
  output logic [X_W-1:0] out_b
);
  localparam int CH = NCH;

  logic [CH-1:0][X_W-1:0]   px_in, px_out;
  logic [CH-1:0][SEG_W-1:0] seg_idx;
  logic [CH-1:0][BW-1:0]    bp_lo, bp_hi;
  logic [CH-1:0]            lane_v;

  assign px_in = {in_b, in_g, in_r};

  gamma_bp_bank #(.CH(CH), .BW(BW), .NB(NBP), .AW(AW), .SW(SEG_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .commit(frame_start), .rd_idx(seg_idx), .rd_lo(bp_lo), .rd_hi(bp_hi)
  );

  for (genvar c = 0; c < CH; c++) begin : g_lane
    gamma_lane #(.X_W(X_W), .BW(BW), .SW(SEG_W), .OW(OFF_W), .HW(SH_W)) u_lane (
      .clk(clk), .rst(rst), .in_valid(in_valid), .curve_en(curve_en),
      .x(px_in[c]), .seg_idx(seg_idx[c]), .bp_lo(bp_lo[c]), .bp_hi(bp_hi[c]),
      .out_valid(lane_v[c]), .out_x(px_out[c])
    );
  end

  assign out_valid = lane_v[0];
  assign out_r = px_out[0];
  assign out_g = px_out[1];
  assign out_b = px_out[2];

  // R2: fixed two-cycle latency
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);
  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid);
  // R3: pass-through leaves the pixel unchanged
  assert_bypass_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !curve_en) |=> ##1
      (out_r == $past(in_r, 2) && out_g == $past(in_g, 2) && out_b == $past(in_b, 2)));
endmodule

// File: tb/sim_gamma_pwl_curve.sv
module sim_gamma_pwl_curve;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [12:0] wr_data = '0;
  logic        frame_start = 1'b0;
  logic        curve_en = 1'b0;
  logic        in_valid = 1'b0;
  logic [11:0] in_r = '0, in_g = '0, in_b = '0;
  logic        out_valid;
  logic [11:0] out_r, out_g, out_b;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int shd_m[65];
  int act_m[65];

  always #10 clk = ~clk;

  gamma_pwl_curve u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_start(frame_start), .curve_en(curve_en), .in_valid(in_valid),
    .in_r(in_r), .in_g(in_g), .in_b(in_b),
    .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // curve model built from the segment table of R4 and the formula of R5/R6
  function automatic int model(input int x, input bit en);
    int st[8] = '{0, 16, 32, 64, 128, 256, 512, 1024};
    int nn[8] = '{4, 4, 4, 4, 4, 4, 16, 24};
    int ww[8] = '{4, 4, 8, 16, 32, 64, 32, 128};
    int k, sg, s, w, num, q, v;
    if (!en) return x;
    k = 0; sg = 0; s = 0; w = 4;
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < nn[i]; j++) begin
        if (x >= st[i] + j * ww[i] && x < st[i] + (j + 1) * ww[i]) begin
          sg = k; s = st[i] + j * ww[i]; w = ww[i];
        end
        k++;
      end
    num = (act_m[sg + 1] - act_m[sg]) * (x - s);
    q = num / w;
    if (num < 0 && (num % w) != 0) q = q - 1;
    v = act_m[sg] + q;
    if (v > 4095) v = 4095;
    if (v < 0) v = 0;
    return v;
  endfunction

  task automatic px(input int r, input int g, input int b, input bit en, input string req);
    int er, eg, eb;
    er = model(r, en); eg = model(g, en); eb = model(b, en);
    @(negedge clk);
    in_valid = 1'b1; curve_en = en;
    in_r = 12'(r); in_g = 12'(g); in_b = 12'(b);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b0, "R2", int'(out_valid), 0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R2", int'(out_valid), 1);
    chk(out_r == 12'(er), req, int'(out_r), er);
    chk(out_g == 12'(eg), {req, "/R9"}, int'(out_g), eg);
    chk(out_b == 12'(eb), {req, "/R9"}, int'(out_b), eb);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'(a); wr_data = 13'(d);
    @(negedge clk);
    wr_en = 1'b0;
    if (a < 65) shd_m[a] = d;
  endtask

  task automatic commit();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    act_m = shd_m;
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    chk(out_r == 12'd0 && out_g == 12'd0 && out_b == 12'd0, "R1", int'(out_r), 0);
  endtask

  task automatic t_identity();
    px(0, 17, 4095, 1'b1, "R1");
    px(1023, 1024, 511, 1'b1, "R1");
    px(3968, 33, 250, 1'b1, "R1");
  endtask

  task automatic t_latency();
    px(5, 6, 7, 1'b1, "R2");
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", int'(out_valid), 0);
  endtask

  task automatic t_shadow_hold();
    for (int k = 0; k < 63; k++) wr(k, (k * 517 + 300) % 4096);
    wr(63, 4000);
    wr(64, 8191);
    // not yet committed: still identity (R8)
    px(100, 2000, 4095, 1'b1, "R8");
    commit();
  endtask

  task automatic t_curve();
    int bnd[16] = '{0, 3, 15, 16, 31, 32, 63, 64, 127, 128, 255, 256, 511, 512, 1023, 1024};
    for (int i = 0; i < 16; i++) px(bnd[i], 4095 - bnd[i], (bnd[i] * 3 + 1) % 4096, 1'b1, "R4");
    for (int i = 0; i < 40; i++) begin
      int x;
      x = (i * 101 + 5) % 4096;
      px(x, (x * 7 + 13) % 4096, 4095 - x, 1'b1, "R5");
    end
  endtask

  task automatic t_saturate();
    px(4095, 3968, 4000, 1'b1, "R6");
    px(4031, 3969, 4094, 1'b1, "R10");
  endtask

  task automatic t_bypass();
    px(4095, 1234, 7, 1'b0, "R3");
    px(0, 3000, 512, 1'b0, "R3");
  endtask

  task automatic t_bad_addr();
    wr(65, 123);
    wr(127, 456);
    wr(66, 789);
    commit();
    px(4, 0, 4095, 1'b1, "R7");
    px(8, 3968, 2, 1'b1, "R7");
  endtask

  task automatic t_write_at_commit();
    int old0;
    old0 = act_m[0];
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 7'd0; wr_data = 13'd2222; frame_start = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; frame_start = 1'b0;
    act_m = shd_m;
    shd_m[0] = 2222;
    px(0, 0, 0, 1'b1, "R8");
    chk(out_r == 12'(old0), "R8", int'(out_r), old0);
    commit();
    px(0, 1, 2, 1'b1, "R8");
    chk(out_r == 12'd2222, "R8", int'(out_r), 2222);
  endtask

  initial begin
    for (int k = 0; k < 65; k++) begin
      shd_m[k] = (k < 8) ? k * 4 : (k < 12) ? 32 + (k - 8) * 8 :
                 (k < 16) ? 64 + (k - 12) * 16 : (k < 20) ? 128 + (k - 16) * 32 :
                 (k < 24) ? 256 + (k - 20) * 64 : (k < 40) ? 512 + (k - 24) * 32 :
                 (k < 64) ? 1024 + (k - 40) * 128 : 4096;
    end
    act_m = shd_m;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_identity();
    t_latency();
    t_shadow_hold();
    t_curve();
    t_saturate();
    t_bypass();
    t_bad_addr();
    t_write_at_commit();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule